// File: doc/BRIEF.md
# Priority-Threshold Interrupt Controller

This block gathers a set of level-sensitive interrupt request lines and steers each one to one of two processor interrupt outputs: a fast output and a normal output. Every line carries its own small configuration word that sets four things. The first is its priority, where zero disables the line. The second chooses the output it drives. The third selects whether a low or a high level counts as a request. The fourth is a software request bit that raises the line's request without the hardware line being active.

For each output, the block keeps a programmable threshold. Only pending requests whose priority is strictly above that threshold can assert the output, so an interrupt handler can raise the threshold to its own level and let only more urgent sources nest on top of it. Among the qualifying requests, the highest priority wins, and equal priorities are resolved in favour of the lower line index. The winner's index is captured in a per-output vector register together with a valid flag. Software reads that register instead of scanning the lines. A plain synchronous register port carries all configuration, threshold, vector and raw-status accesses.

Top module: `prio_intc`

## Requirements
- R1: After reset, every line's configuration word (all four fields) is zero and both thresholds are zero. Both outputs are low and both vector registers read 0.
- R2: When a line's polarity bit (config bit 5) is 1, a low level on that line is a request; when it is 0, a high level is a request.
- R3: A line's software request bit (config bit 6) produces a request exactly as an active hardware level does.
- R4: Address 68 returns raw request state for lines 0..31 in bits 31..0, and address 69 returns lines 32..55 in bits 23..0. Each raw bit is (line level XOR polarity) OR software request. It does not depend on priority, target or threshold, and it follows the line levels in the same cycle.
- R5: A line whose priority field (config bits 3:0) is 0 never asserts an output and never appears in a vector.
- R6: A line's target bit (config bit 4) routes it to the fast output when 0 and to the normal output when 1.
- R7: A request can reach an output only when its priority is strictly greater than that output's threshold. The fast threshold is at address 64 and the normal threshold at address 65, each in bits 3:0.
- R8: For each output, the winner is the qualifying request with the highest priority; on equal priority the lower line index wins.
- R9: The vector registers sit at address 66 (fast) and 67 (normal). Each holds the valid flag in bit 31 and the winning line index in bits 5:0. The vector registers and the outputs update on the clock edge after the inputs or configuration that cause them, and an output is high exactly when its vector is valid.
- R10: The configuration word of line i is written and read at address i (0..55) in bits 6:0, with higher bits reading 0. Writes to unused addresses have no effect, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | 56 | Interrupt request lines |
| regAddr | input | 7 | Register address |
| regWrEn | input | 1 | Write strobe for the addressed register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for the addressed register (combinational) |
| fiqOut | output | 1 | Fast interrupt output, registered |
| irqOut | output | 1 | Normal interrupt output, registered |

## Verification
On every cycle, the bound checker confirms four properties of each valid vector. The winning line had a raw request one cycle earlier. Its priority was non-zero and above the output's threshold. Its target bit selected that output, and its index lies inside the line range. Selecting the single best line among several, with the index tie-break, is something only the bench can show. The same holds for the polarity and software-request paths, the readback map, and the absence of effects from writes to unused addresses. For these, the bench's behavioural model is compared against the outputs and read data on every clock, through directed scenarios and a long random phase.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int NUM_SRC  = 56;
  localparam int PRIO_W   = 4;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 7;
  localparam int IDX_W    = $clog2(NUM_SRC);
  localparam int NUM_TGT  = 2;

  localparam int ADDR_THR = 64;
  localparam int ADDR_VEC = 66;
  localparam int ADDR_RAW = 68;

  localparam int CFG_PRIO_LSB = 0;
  localparam int CFG_TGT_BIT  = PRIO_W;
  localparam int CFG_POL_BIT  = PRIO_W + 1;
  localparam int CFG_SW_BIT   = PRIO_W + 2;
  localparam int CFG_W        = PRIO_W + 3;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_CFG,
    RD_THR,
    RD_VEC,
    RD_RAW
  } rd_sel_e;

  typedef struct packed {
    logic               cfgWe;
    logic [IDX_W-1:0]   idx;
    logic [NUM_TGT-1:0] thrWe;
    rd_sel_e            rdSel;
    logic               sub;
  } strobe_t;
endpackage

// File: rtl/prio_intc_arbiter.sv
module prio_intc_arbiter
  import prio_intc_pkg::*;
#(
  parameter int N   = NUM_SRC,
  parameter int PW  = PRIO_W,
  parameter int IW  = IDX_W,
  parameter bit TGT = 1'b0
) (
  input  logic [N-1:0]    rawReq,
  input  logic [N*PW-1:0] prioFlat,
  input  logic [N-1:0]    tgtVec,
  input  logic [PW-1:0]   threshold,
  output logic            winValid,
  output logic [IW-1:0]   winIdx
);
  logic [PW-1:0] bestPrio;
  logic [IW-1:0] bestIdx;

  always_comb begin
    bestPrio = '0;
    bestIdx  = '0;
    for (int i = 0; i < N; i++) begin
      // strict compare keeps the earlier (lower) index on a tie
      if (rawReq[i] && (tgtVec[i] == TGT) &&
          (prioFlat[i*PW +: PW] > threshold) &&
          (prioFlat[i*PW +: PW] > bestPrio)) begin
        bestPrio = prioFlat[i*PW +: PW];
        bestIdx  = IW'(i);
      end
    end
  end

  assign winValid = (bestPrio != '0);
  assign winIdx   = bestIdx;
endmodule

// File: rtl/prio_intc_ctrl.sv
module prio_intc_ctrl
  import prio_intc_pkg::*;
#(
  parameter int N  = NUM_SRC,
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] regAddr,
  input  logic          regWrEn,
  output strobe_t       stb
);
  logic isCfg;
  logic isThr;
  logic isVec;
  logic isRaw;

  assign isCfg = (int'(regAddr) < N);
  assign isThr = (int'(regAddr) >= ADDR_THR) && (int'(regAddr) < ADDR_THR + NUM_TGT);
  assign isVec = (int'(regAddr) >= ADDR_VEC) && (int'(regAddr) < ADDR_VEC + NUM_TGT);
  assign isRaw = (int'(regAddr) >= ADDR_RAW) && (int'(regAddr) < ADDR_RAW + 2);

  always_comb begin
    stb       = '0;
    stb.idx   = regAddr[IDX_W-1:0];
    stb.sub   = regAddr[0];
    stb.cfgWe = regWrEn && isCfg;
    for (int t = 0; t < NUM_TGT; t++) begin
      stb.thrWe[t] = regWrEn && (int'(regAddr) == ADDR_THR + t);
    end
    if (isCfg)      stb.rdSel = RD_CFG;
    else if (isThr) stb.rdSel = RD_THR;
    else if (isVec) stb.rdSel = RD_VEC;
    else if (isRaw) stb.rdSel = RD_RAW;
    else            stb.rdSel = RD_NONE;
  end
endmodule

// File: rtl/prio_intc_datapath.sv
module prio_intc_datapath
  import prio_intc_pkg::*;
#(
  parameter int N  = NUM_SRC,
  parameter int PW = PRIO_W,
  parameter int DW = DATA_W,
  parameter int IW = IDX_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [N-1:0]          irqIn,
  input  strobe_t               stb,
  input  logic [DW-1:0]         wrData,
  output logic [DW-1:0]         rdData,
  output logic [N-1:0]          rawReq,
  output logic [N*PW-1:0]       prioFlat,
  output logic [N-1:0]          tgtVec,
  output logic [NUM_TGT*PW-1:0] thrFlat,
  output logic [NUM_TGT-1:0]    vecValid,
  output logic [NUM_TGT*IW-1:0] vecIdx
);
  localparam int RAW_PAD_W = 2 * DW;

  logic [PW-1:0] prioQ [N];
  logic [N-1:0]  polQ;
  logic [N-1:0]  swQ;
  logic [PW-1:0] thrQ  [NUM_TGT];
  logic [IW-1:0] vIdxQ [NUM_TGT];
  logic [NUM_TGT-1:0] vValidQ;
  logic [RAW_PAD_W-1:0] rawPad;

  // per-line configuration storage
  for (genvar g = 0; g < N; g++) begin : gLine
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prioQ[g]  <= '0;
        tgtVec[g] <= 1'b0;
        polQ[g]   <= 1'b0;
        swQ[g]    <= 1'b0;
      end else if (stb.cfgWe && (stb.idx == IW'(g))) begin
        prioQ[g]  <= wrData[CFG_PRIO_LSB +: PW];
        tgtVec[g] <= wrData[CFG_TGT_BIT];
        polQ[g]   <= wrData[CFG_POL_BIT];
        swQ[g]    <= wrData[CFG_SW_BIT];
      end
    end
    assign prioFlat[g*PW +: PW] = prioQ[g];
  end

  assign rawReq = (irqIn ^ polQ) | swQ;
  assign rawPad = RAW_PAD_W'(rawReq);

  // per-target threshold, arbiter and vector register
  for (genvar t = 0; t < NUM_TGT; t++) begin : gTgt
    logic          winValid;
    logic [IW-1:0] winIdx;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              thrQ[t] <= '0;
      else if (stb.thrWe[t])  thrQ[t] <= wrData[PW-1:0];
    end

    prio_intc_arbiter #(
      .N(N), .PW(PW), .IW(IW), .TGT(t[0])
    ) uArb (
      .rawReq   (rawReq),
      .prioFlat (prioFlat),
      .tgtVec   (tgtVec),
      .threshold(thrQ[t]),
      .winValid (winValid),
      .winIdx   (winIdx)
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vValidQ[t] <= 1'b0;
        vIdxQ[t]   <= '0;
      end else begin
        vValidQ[t] <= winValid;
        vIdxQ[t]   <= winValid ? winIdx : '0;
      end
    end

    assign thrFlat[t*PW +: PW] = thrQ[t];
    assign vecIdx[t*IW +: IW]  = vIdxQ[t];
  end

  assign vecValid = vValidQ;

  // read mux
  always_comb begin
    rdData = '0;
    unique case (stb.rdSel)
      RD_CFG: begin
        rdData[CFG_PRIO_LSB +: PW] = prioQ[stb.idx];
        rdData[CFG_TGT_BIT]        = tgtVec[stb.idx];
        rdData[CFG_POL_BIT]        = polQ[stb.idx];
        rdData[CFG_SW_BIT]         = swQ[stb.idx];
      end
      RD_THR: rdData[PW-1:0] = thrQ[stb.sub];
      RD_VEC: begin
        rdData[DW-1]   = vValidQ[stb.sub];
        rdData[IW-1:0] = vIdxQ[stb.sub];
      end
      RD_RAW: rdData = stb.sub ? rawPad[RAW_PAD_W-1:DW] : rawPad[DW-1:0];
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int N  = NUM_SRC,
  parameter int PW = PRIO_W,
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [N-1:0]  irqIn,
  input  logic [AW-1:0] regAddr,
  input  logic          regWrEn,
  input  logic [DW-1:0] regWrData,
  output logic [DW-1:0] regRdData,
  output logic          fiqOut,
  output logic          irqOut
);
  localparam int IW = IDX_W;

  strobe_t                stb;
  logic [N-1:0]           rawReq;
  logic [N*PW-1:0]        prioFlat;
  logic [N-1:0]           tgtVec;
  logic [NUM_TGT*PW-1:0]  thrFlat;
  logic [NUM_TGT-1:0]     vecValid;
  logic [NUM_TGT*IW-1:0]  vecIdx;

  prio_intc_ctrl #(.N(N), .AW(AW)) uCtrl (
    .regAddr(regAddr),
    .regWrEn(regWrEn),
    .stb    (stb)
  );

  prio_intc_datapath #(.N(N), .PW(PW), .DW(DW), .IW(IW)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .irqIn   (irqIn),
    .stb     (stb),
    .wrData  (regWrData),
    .rdData  (regRdData),
    .rawReq  (rawReq),
    .prioFlat(prioFlat),
    .tgtVec  (tgtVec),
    .thrFlat (thrFlat),
    .vecValid(vecValid),
    .vecIdx  (vecIdx)
  );

  assign fiqOut = vecValid[0];
  assign irqOut = vecValid[1];
endmodule

// File: rtl/prio_intc_checker.sv
module prio_intc_checker
  import prio_intc_pkg::*;
#(
  parameter int N  = NUM_SRC,
  parameter int PW = PRIO_W,
  parameter int IW = IDX_W
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [N-1:0]          rawReq,
  input logic [N*PW-1:0]       prioFlat,
  input logic [N-1:0]          tgtVec,
  input logic [NUM_TGT*PW-1:0] thrFlat,
  input logic [NUM_TGT-1:0]    vecValid,
  input logic [NUM_TGT*IW-1:0] vecIdx
);
  logic [N-1:0]          pRaw;
  logic [N*PW-1:0]       pPrio;
  logic [N-1:0]          pTgt;
  logic [NUM_TGT*PW-1:0] pThr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pRaw  <= '0;
      pPrio <= '0;
      pTgt  <= '0;
      pThr  <= '0;
    end else begin
      pRaw  <= rawReq;
      pPrio <= prioFlat;
      pTgt  <= tgtVec;
      pThr  <= thrFlat;
    end
  end

  for (genvar t = 0; t < NUM_TGT; t++) begin : gChk
    logic [IW-1:0] idx;
    logic          inRange;
    logic [PW-1:0] winPrio;
    logic          winTgt;
    logic          winRaw;

    assign idx     = vecIdx[t*IW +: IW];
    assign inRange = (int'(idx) < N);
    assign winPrio = inRange ? pPrio[int'(idx)*PW +: PW] : '0;
    assign winTgt  = inRange ? pTgt[idx] : 1'b0;
    assign winRaw  = inRange ? pRaw[idx] : 1'b0;

    assert_idx_range_R9: assert property (@(posedge clk) disable iff (!rstN)
      vecValid[t] |-> inRange);
    assert_prio_nonzero_R5: assert property (@(posedge clk) disable iff (!rstN)
      vecValid[t] |-> (winPrio != '0));
    assert_above_thr_R7: assert property (@(posedge clk) disable iff (!rstN)
      vecValid[t] |-> (winPrio > pThr[t*PW +: PW]));
    assert_route_R6: assert property (@(posedge clk) disable iff (!rstN)
      vecValid[t] |-> (winTgt == t[0]));
    assert_was_pending_R4: assert property (@(posedge clk) disable iff (!rstN)
      vecValid[t] |-> winRaw);
  end
endmodule

bind prio_intc prio_intc_checker #(.N(N), .PW(PW), .IW(IW)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .rawReq  (rawReq),
  .prioFlat(prioFlat),
  .tgtVec  (tgtVec),
  .thrFlat (thrFlat),
  .vecValid(vecValid),
  .vecIdx  (vecIdx)
);

// File: tb/tb_prio_intc.sv
`timescale 1ns/100ps
module tb_prio_intc;
  localparam int N = 56;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [N-1:0] irqIn = '0;
  logic [6:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        fiqOut;
  logic        irqOut;

  int vectors = 0;
  int fails = 0;
  string curReq = "R1";

  // behavioural model state
  int mPrio [N];
  int mTgt  [N];
  int mPol  [N];
  int mSw   [N];
  int mThr  [2];
  int eValid [2];
  int eIdx   [2];

  always #2.5 clk = ~clk;

  prio_intc dut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .fiqOut(fiqOut), .irqOut(irqOut)
  );

  function automatic int rawBit(int i);
    return ((int'(irqIn[i]) ^ mPol[i]) | mSw[i]);
  endfunction

  function automatic logic [31:0] modelRead(int a);
    logic [31:0] r;
    r = '0;
    if (a < N) begin
      r[3:0] = 4'(mPrio[a]);
      r[4] = mTgt[a][0];
      r[5] = mPol[a][0];
      r[6] = mSw[a][0];
    end else if (a == 64 || a == 65) r[3:0] = 4'(mThr[a-64]);
    else if (a == 66 || a == 67) begin
      r[31] = eValid[a-66][0];
      r[5:0] = 6'(eIdx[a-66]);
    end else if (a == 68) begin
      for (int i = 0; i < 32; i++) r[i] = rawBit(i)[0];
    end else if (a == 69) begin
      for (int i = 32; i < N; i++) r[i-32] = rawBit(i)[0];
    end
    return r;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  // model update and per-clock comparison
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) begin
        mPrio[i] = 0; mTgt[i] = 0; mPol[i] = 0; mSw[i] = 0;
      end
      for (int t = 0; t < 2; t++) begin
        mThr[t] = 0; eValid[t] = 0; eIdx[t] = 0;
      end
    end else begin
      for (int t = 0; t < 2; t++) begin
        int bp;
        int bi;
        bp = 0; bi = 0;
        for (int i = 0; i < N; i++)
          if (rawBit(i) == 1 && mTgt[i] == t && mPrio[i] > mThr[t] && mPrio[i] > bp) begin
            bp = mPrio[i]; bi = i;
          end
        eValid[t] = (bp != 0);
        eIdx[t] = bi;
      end
      if (regWrEn) begin
        int a;
        a = int'(regAddr);
        if (a < N) begin
          mPrio[a] = int'(regWrData[3:0]);
          mTgt[a] = int'(regWrData[4]);
          mPol[a] = int'(regWrData[5]);
          mSw[a] = int'(regWrData[6]);
        end else if (a == 64 || a == 65) mThr[a-64] = int'(regWrData[3:0]);
      end
    end
    #1;
    check(curReq, "fiqOut", 32'(fiqOut), 32'(eValid[0]));
    check(curReq, "irqOut", 32'(irqOut), 32'(eValid[1]));
    check(curReq, "regRdData", regRdData, modelRead(int'(regAddr)));
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    regAddr = 7'(a); regWrEn = 1'b1; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic rdCheck(string req, int a, logic [31:0] exp);
    @(negedge clk);
    regAddr = 7'(a);
    #1;
    check(req, $sformatf("read addr %0d", a), regRdData, exp);
  endtask

  task automatic setLine(int i, logic v);
    @(negedge clk);
    irqIn[i] = v;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    curReq = "R1";
    check("R1", "fiqOut after reset", 32'(fiqOut), 32'd0);
    check("R1", "irqOut after reset", 32'(irqOut), 32'd0);
    @(negedge clk); rstN = 1'b1;
    rdCheck("R1", 66, 32'h0);
    rdCheck("R1", 67, 32'h0);
    rdCheck("R1", 12, 32'h0);

    curReq = "R6";
    wr(5, 32'h04);
    setLine(5, 1'b1);
    settle();
    check("R6", "fiqOut for target 0", 32'(fiqOut), 32'd1);
    check("R6", "irqOut for target 0", 32'(irqOut), 32'd0);
    rdCheck("R9", 66, 32'h8000_0005);

    curReq = "R8";
    wr(2, 32'h04);
    setLine(2, 1'b1);
    settle();
    rdCheck("R8", 66, 32'h8000_0002);
    wr(9, 32'h07);
    setLine(9, 1'b1);
    settle();
    rdCheck("R8", 66, 32'h8000_0009);

    curReq = "R7";
    wr(64, 32'h7);
    settle();
    check("R7", "fiqOut with threshold equal to priority", 32'(fiqOut), 32'd0);
    rdCheck("R7", 66, 32'h0);
    wr(64, 32'h6);
    settle();
    rdCheck("R7", 66, 32'h8000_0009);

    curReq = "R5";
    wr(3, 32'h10);
    setLine(3, 1'b1);
    settle();
    check("R5", "irqOut with priority 0", 32'(irqOut), 32'd0);
    curReq = "R4";
    rdCheck("R4", 68, 32'h0000_022C);

    curReq = "R2";
    wr(10, 32'h33);
    settle();
    check("R2", "irqOut active-low line held low", 32'(irqOut), 32'd1);
    rdCheck("R2", 67, 32'h8000_000A);
    setLine(10, 1'b1);
    settle();
    check("R2", "irqOut active-low line high", 32'(irqOut), 32'd0);

    curReq = "R3";
    wr(40, 32'hFFFF_FF55);
    settle();
    rdCheck("R3", 67, 32'h8000_0028);
    rdCheck("R4", 69, 32'h0000_0100);

    curReq = "R10";
    rdCheck("R10", 40, 32'h55);
    wr(65, 32'h2);
    rdCheck("R10", 65, 32'h2);
    wr(60, 32'h7F);
    wr(70, 32'h7F);
    settle();
    rdCheck("R10", 60, 32'h0);
    rdCheck("R10", 66, 32'h8000_0009);
    rdCheck("R10", 67, 32'h8000_0028);

    curReq = "R8";
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      irqIn = {$urandom(), $urandom()};
      regWrEn = ($urandom_range(0, 3) == 0);
      regAddr = ($urandom_range(0, 9) == 0) ? 7'($urandom_range(64, 65))
                                           : 7'($urandom_range(0, 71));
      regWrData = $urandom();
    end
    @(negedge clk);
    regWrEn = 1'b0;
    settle();
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, actual hang expected finish");
    summary();
  end
endmodule